// File: doc/BRIEF.md
# Address-Bus Master Arbitration Handshake

This block is the requesting side of a shared address bus whose owner is chosen by an external arbiter. When the local core raises its need for the bus, the block either asks for it with an active-low request line or, if the arbiter has already parked the grant on it, skips the request. It takes address-bus ownership only when three conditions hold in the same cycle: the grant is low, the bus is not busy and no retry is signalled. Ownership is shown by driving the shared busy line low.

A tenure ends in one of two ways. If an address acknowledge arrives, the busy line is driven high for one cycle and then released. If a retry arrives instead, the block releases the busy line at once and waits out a back-off window. It then asks for the bus again if the core still needs it. All bus lines are active-low and are sampled on the rising clock edge. The shared busy line leaves the block as a value and an output enable, for an outside tri-state pad.

Top module: `bus_addr_master`

## Requirements
- R1: While reset is low and in the first cycle after it, bus_req_n is 1, busy_oe is 0, busy_out_n is 1, and tenure_active and tenure_done are 0.
- R2: From idle with need_bus high: if the grant is qualified (grant_n=0, busy_in_n=1, retry_n=1), tenure starts on the next cycle and bus_req_n never goes low. Otherwise bus_req_n goes low on the next cycle.
- R3: Once bus_req_n is low, it stays low through every input combination that is not a qualified grant. need_bus has no effect while requesting.
- R4: A tenure starts only in the cycle after a qualified grant is sampled. While tenure_active is 1, busy_oe is 1 and busy_out_n is 0.
- R5: bus_req_n is high in every cycle in which the block drives the busy line low.
- R6: If addr_ack_n=0 and retry_n=1 are sampled during a tenure, the next cycle has busy_oe=1, busy_out_n=1 and tenure_done=1. The cycle after that has busy_oe=0.
- R7: If retry_n=0 is sampled during a tenure, this takes priority over an acknowledge in the same cycle. The next cycle has busy_oe=0 and bus_req_n=1. bus_req_n stays high for BACKOFF_CYC+1 cycles and then goes low if need_bus is still high and no parked grant is present.
- R8: During a tenure with neither acknowledge nor retry sampled, busy_out_n stays low and busy_oe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| need_bus | input | 1 | Core wants an address tenure (active high) |
| grant_n | input | 1 | Arbiter grant, active low |
| busy_in_n | input | 1 | Sampled shared address-busy line, active low |
| retry_n | input | 1 | Address retry, active low |
| addr_ack_n | input | 1 | Address acknowledge, active low |
| bus_req_n | output | 1 | Bus request to arbiter, active low |
| busy_out_n | output | 1 | Value driven onto the shared busy line |
| busy_oe | output | 1 | Output enable for the busy line pad |
| tenure_active | output | 1 | Block owns the address bus this cycle |
| tenure_done | output | 1 | One-cycle pulse when a tenure completes by acknowledge |

## Verification
A wrong control state shows on the port bundle one cycle after the edge that caused it. Every state has its own pattern on the request, enable, busy and tenure outputs, except back-off and idle, which match. Those two are told apart by how long the request stays high after a retry, so a bad back-off count shows at the exact cycle the request returns. The bench sweeps every grant, busy and retry combination from both idle and requesting, and every retry and acknowledge pair during tenure.

// File: rtl/bus_addr_master_pkg.sv
// Package: shared state type for the address-bus master handshake.
package bus_addr_master_pkg;

    // Control states of the handshake.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ     = 3'd1,
        ST_OWN     = 3'd2,
        ST_RELEASE = 3'd3,
        ST_BACKOFF = 3'd4
    } mst_state_e;

endpackage

// File: rtl/bus_addr_qual.sv
// Module: bus_addr_qual
// Decides whether this cycle's arbiter inputs form a qualified grant.
// Assumes all inputs are active low and already stable at the sampling edge.
module bus_addr_qual (
    input  logic grant_n,
    input  logic busy_in_n,
    input  logic retry_n,
    output logic qual_grant
);
    // Grant is usable only with bus idle and no retry in the same cycle.
    always_comb begin
        qual_grant = ~grant_n & busy_in_n & retry_n;
    end
endmodule

// File: rtl/bus_addr_backoff.sv
// Module: bus_addr_backoff
// Down-counter that times the quiet window after a retried tenure.
// Assumes COUNT >= 1. The start pulse is one cycle long and loads COUNT-1.
module bus_addr_backoff #(
    parameter int COUNT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CW = (COUNT < 2) ? 1 : $clog2(COUNT + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(COUNT - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The window is over once the counter has reached zero.
    always_comb begin
        expired = (cnt_q == '0);
    end
endmodule

// File: rtl/bus_addr_fsm.sv
// Module: bus_addr_fsm
// Sequencing of request, tenure, release and back-off.
// Assumes need_bus is a level that the core holds until tenure_done is seen.
// A retry sampled during a tenure takes priority over an acknowledge.
module bus_addr_fsm
    import bus_addr_master_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       need_bus,
    input  logic       qual_grant,
    input  logic       retry_n,
    input  logic       addr_ack_n,
    input  logic       bk_expired,
    output logic       bk_start,
    output mst_state_e state
);
    mst_state_e state_q, state_d;

    // Next-state selection from sampled bus inputs.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (need_bus) begin
                    state_d = qual_grant ? ST_OWN : ST_REQ;
                end
            end
            ST_REQ: begin
                if (qual_grant) begin
                    state_d = ST_OWN;
                end
            end
            ST_OWN: begin
                if (!retry_n) begin
                    state_d = ST_BACKOFF;
                end else if (!addr_ack_n) begin
                    state_d = ST_RELEASE;
                end
            end
            ST_RELEASE: state_d = ST_IDLE;
            ST_BACKOFF: begin
                if (bk_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Back-off window begins on the edge that leaves the tenure on retry.
    always_comb begin
        bk_start = (state_q == ST_OWN) && !retry_n;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/bus_addr_master.sv
// Module: bus_addr_master (top)
// Master-side handshake for a shared address bus with an external arbiter.
// All bus lines are active low. The shared busy line is produced as a value
// plus an output enable, and the pad is outside this block.
module bus_addr_master
    import bus_addr_master_pkg::*;
#(
    parameter int BACKOFF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic need_bus,
    input  logic grant_n,
    input  logic busy_in_n,
    input  logic retry_n,
    input  logic addr_ack_n,
    output logic bus_req_n,
    output logic busy_out_n,
    output logic busy_oe,
    output logic tenure_active,
    output logic tenure_done
);
    logic       qual_grant;
    logic       bk_start;
    logic       bk_expired;
    mst_state_e state;

    bus_addr_qual u_qual (
        .grant_n    (grant_n),
        .busy_in_n  (busy_in_n),
        .retry_n    (retry_n),
        .qual_grant (qual_grant)
    );

    bus_addr_backoff #(.COUNT(BACKOFF_CYC)) u_backoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (bk_start),
        .expired (bk_expired)
    );

    bus_addr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .need_bus   (need_bus),
        .qual_grant (qual_grant),
        .retry_n    (retry_n),
        .addr_ack_n (addr_ack_n),
        .bk_expired (bk_expired),
        .bk_start   (bk_start),
        .state      (state)
    );

    // Port values decoded from the registered state, so all are glitch-free.
    always_comb begin
        bus_req_n     = 1'b1;
        busy_out_n    = 1'b1;
        busy_oe       = 1'b0;
        tenure_active = 1'b0;
        tenure_done   = 1'b0;
        unique case (state)
            ST_REQ:  bus_req_n = 1'b0;
            ST_OWN: begin
                busy_oe       = 1'b1;
                busy_out_n    = 1'b0;
                tenure_active = 1'b1;
            end
            ST_RELEASE: begin
                busy_oe     = 1'b1;
                tenure_done = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_addr_master_chk.sv
// Module: bus_addr_master_chk
// Port-level protocol checks, attached to every bus_addr_master by bind.
module bus_addr_master_chk (
    input logic clk,
    input logic rst_n,
    input logic grant_n,
    input logic busy_in_n,
    input logic retry_n,
    input logic addr_ack_n,
    input logic bus_req_n,
    input logic busy_out_n,
    input logic busy_oe,
    input logic tenure_active,
    input logic tenure_done
);
    // Request stays asserted until a qualified grant is seen.
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req_n && !(!grant_n && busy_in_n && retry_n)) |=> !bus_req_n);

    // Tenure rises only after a qualified grant.
    assert_qual_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tenure_active) |-> $past(!grant_n && busy_in_n && retry_n));

    // Never request while driving busy low.
    assert_req_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_oe && !busy_out_n) |-> bus_req_n);

    // Acknowledge leads to one negated cycle, then release.
    assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tenure_active && !addr_ack_n && retry_n) |=> (busy_oe && busy_out_n && tenure_done));

    assert_hiz_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tenure_done |=> !busy_oe);

    // Retry drops the bus at once and keeps the request off.
    assert_retry_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tenure_active && !retry_n) |=> (!busy_oe && bus_req_n));

    // Tenure holds without acknowledge or retry.
    assert_tenure_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tenure_active && addr_ack_n && retry_n) |=> (tenure_active && !busy_out_n));
endmodule

bind bus_addr_master bus_addr_master_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .grant_n       (grant_n),
    .busy_in_n     (busy_in_n),
    .retry_n       (retry_n),
    .addr_ack_n    (addr_ack_n),
    .bus_req_n     (bus_req_n),
    .busy_out_n    (busy_out_n),
    .busy_oe       (busy_oe),
    .tenure_active (tenure_active),
    .tenure_done   (tenure_done)
);

// File: tb/bus_addr_master_bench.sv
// Bench: sweeps inputs from idle, requesting and tenure states.
module bus_addr_master_bench;
    localparam int BK = 2;
    // Port bundle {bus_req_n, busy_oe, busy_out_n, tenure_active, tenure_done}
    localparam logic [4:0] P_IDLE = 5'b10100;
    localparam logic [4:0] P_REQ  = 5'b00100;
    localparam logic [4:0] P_OWN  = 5'b11010;
    localparam logic [4:0] P_REL  = 5'b11101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic need_bus = 1'b0, grant_n = 1'b1, busy_in_n = 1'b1, retry_n = 1'b1, addr_ack_n = 1'b1;
    logic bus_req_n, busy_out_n, busy_oe, tenure_active, tenure_done;
    int n_chk = 0, n_bad = 0;
    bit fin = 1'b0;

    always #2.5 clk = ~clk;

    bus_addr_master #(.BACKOFF_CYC(BK)) u_bus_addr_master (
        .clk(clk), .rst_n(rst_n), .need_bus(need_bus), .grant_n(grant_n),
        .busy_in_n(busy_in_n), .retry_n(retry_n), .addr_ack_n(addr_ack_n),
        .bus_req_n(bus_req_n), .busy_out_n(busy_out_n), .busy_oe(busy_oe),
        .tenure_active(tenure_active), .tenure_done(tenure_done)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic nd, input logic g, input logic b, input logic r, input logic a);
        need_bus = nd; grant_n = g; busy_in_n = b; retry_n = r; addr_ack_n = a;
    endtask

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {bus_req_n, busy_oe, busy_out_n, tenure_active, tenure_done};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ports=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // From the tenure: acknowledge, then release (R6).
    task automatic finish_own();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        step(); check("R6 negate", P_REL);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        step(); check("R6 release", P_IDLE);
    endtask

    initial begin
        step(); check("R1 in reset", P_IDLE);
        step(); rst_n = 1'b1;
        check("R1 after reset", P_IDLE);

        // Sweep from requesting: every grant/busy/retry combination (R3, R4, R5, R8).
        for (int c = 0; c < 8; c++) begin
            drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
            step(); check("R2 request", P_REQ);
            drive(1'b0, c[2], c[1], c[0], 1'b1);
            step();
            if (!c[2] && c[1] && c[0]) begin
                check("R4 qualified from request", P_OWN);
            end else begin
                check("R3 request held", P_REQ);
                drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
                step(); check("R5 take after request", P_OWN);
            end
            drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
            step(); check("R8 tenure held", P_OWN);
            finish_own();
        end

        // Sweep from idle: parked fast path versus request (R2).
        for (int c = 0; c < 8; c++) begin
            drive(1'b1, c[2], c[1], c[0], 1'b1);
            step();
            if (!c[2] && c[1] && c[0]) begin
                check("R2 parked take", P_OWN);
            end else begin
                check("R2 not parked", P_REQ);
                drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
                step(); check("R4 take", P_OWN);
            end
            finish_own();
        end

        // Sweep retry/acknowledge during tenure (R6, R7, R8).
        for (int c = 0; c < 4; c++) begin
            drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
            step(); check("R2 parked take", P_OWN);
            drive(1'b1, 1'b1, 1'b1, c[1], c[0]);
            step();
            if (!c[1]) begin
                check("R7 retry drop", P_IDLE);
                drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
                for (int i = 0; i < BK; i++) begin
                    step(); check("R7 back-off quiet", P_IDLE);
                end
                step(); check("R7 re-request", P_REQ);
                drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
                step(); check("R4 retake", P_OWN);
                finish_own();
            end else if (!c[0]) begin
                check("R6 negate", P_REL);
                drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
                step(); check("R6 release", P_IDLE);
            end else begin
                check("R8 tenure held", P_OWN);
                finish_own();
            end
        end

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: ports=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule